// File: doc/BRIEF.md
# UART Receive Line Status and Error-Tagged Receive FIFO

This block is the receive-side status keeper of a classic 16550-compatible UART. A receive shift register, which is outside the block, delivers each assembled character in a one-cycle strobe. The strobe carries the character's parity, framing and break flags. The block stores the character and its flags together in a small first-in-first-out queue. The CPU sees the oldest character on a buffer output. It also sees an 8-bit line status word, which it reads through a status-read strobe.

Error flags move through the queue with their character. They are shown in the status word only when that character becomes the oldest entry. A summary bit reports whether any errored character is still queued. A character that arrives when the queue is full is thrown away, and the stored characters are kept. The block also follows holding-register and shift-register occupancy from three strobes of the transmit side, and uses them to drive the two transmit-empty bits.

When the queue is disabled, it behaves as a single holding register. A change of the enable input empties the queue.

Top module: `uart_rx_line_status`

## Requirements
- R1: Status bit 0 is 1 exactly when at least one unread character is queued. A buffer read while the queue is empty changes nothing.
- R2: Characters come out in arrival order. `buf_data` shows the oldest character, and a buffer read removes it at the clock edge.
- R3: A character that arrives while the queue is full is dropped, and the queued contents are kept. Full means 16 entries when enabled and 1 entry when disabled, judged at the start of the cycle even if a buffer read happens in the same cycle. The arrival sets status bit 1 (overrun).
- R4: A status read returns the word as it stands before the edge. At that edge the read clears bits 1 to 4.
- R5: Bits 2, 3 and 4 are the parity, framing and break flags of the character that becomes the oldest entry. They are OR-ed in at the edge where it arrives at the head, and they stay until a status read.
- R6: Bit 5 is 0 after a holding-register write (`thr_wr`). It returns to 1 when the serializer takes the character (`tsr_load` while the holding register is full). A `tsr_load` with an empty holding register is ignored, and a write in the same cycle as a take leaves the holding register full.
- R7: Bit 6 is 1 only when both the holding register and the shift register are empty. `tsr_load` fills the shift register, and `tsr_done` empties it unless a load happens in the same cycle.
- R8: Bit 7 is set when a character carrying any error flag is accepted into the queue. A status read clears it only if no errored character remains queued after that edge.
- R9: With the queue disabled (`fifo_en` = 0), bit 7 reads 0 and the queue holds one character.
- R10: A change of `fifo_en` empties the queue at the next edge and drops any character arriving in that cycle.
- R11: A status bit set in the same cycle as a status read stays set.
- R12: After reset the status word is 0x60: bits 5 and 6 set and all others clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| rx_valid | input | 1 | One-cycle strobe: a character has been assembled |
| rx_data | input | 8 | Assembled character |
| rx_parity_err | input | 1 | Parity flag of the character |
| rx_frame_err | input | 1 | Stop-bit flag of the character |
| rx_break | input | 1 | Break flag of the character |
| buf_rd | input | 1 | CPU read of the receive buffer (pops at the edge) |
| lsr_rd | input | 1 | CPU read of the status word (clears at the edge) |
| thr_wr | input | 1 | CPU write of the transmit holding register |
| tsr_load | input | 1 | Serializer moves the holding register into the shift register |
| tsr_done | input | 1 | Serializer has shifted out its last bit |
| buf_data | output | 8 | Oldest queued character, 0 when the queue is empty |
| lsr | output | 8 | Line status word |

## Verification
Every stimulus takes effect at the rising edge that samples it. Its effect appears on `lsr` and `buf_data` just after that same edge: one cycle, with no further pipeline delay. A status read or buffer read returns the value present before that edge.

The bench drives inputs at the falling edge. It compares any read value a moment later, while the strobe is still high, and then compares the complete status word 1 ns after the rising edge. This means each result is checked in the cycle it is due. A reference model built from the requirements supplies the expected values, and a queue of expected characters serves as the scoreboard for buffer reads.

// File: rtl/uls_pkg.sv
package uls_pkg;

    localparam int DATA_W = 8;

    // Error flags that travel with each queued character
    typedef struct packed {
        logic brk;
        logic ferr;
        logic perr;
    } err_flags_t;

    typedef struct packed {
        err_flags_t flags;
        logic [DATA_W-1:0] data;
    } rx_entry_t;

    // Status word; bit positions are the software-visible encoding
    typedef struct packed {
        logic rx_err_sum;   // bit 7
        logic tx_idle;      // bit 6
        logic thr_empty;    // bit 5
        logic brk;          // bit 4
        logic ferr;         // bit 3
        logic perr;         // bit 2
        logic overrun;      // bit 1
        logic data_ready;   // bit 0
    } lsr_t;

    localparam int LSR_W = $bits(lsr_t);

    function automatic logic has_err(input rx_entry_t e);
        return e.flags.perr | e.flags.ferr | e.flags.brk;
    endfunction

endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo
    import uls_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      fifo_en,
    input  logic      push,
    input  rx_entry_t push_entry,
    input  logic      pop,
    output rx_entry_t head_entry,
    output logic      not_empty,
    output logic      overrun_evt,
    output logic      push_err,
    output logic      head_load,
    output err_flags_t head_flags,
    output logic      err_none_next
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   rd_ptr, wr_ptr, rd_ptr_p1;
    logic [CW-1:0]   count, count_n, err_cnt, err_cnt_n, cap;
    logic            fifo_en_q, flush, full, push_ok, pop_ok, pop_err;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign flush     = fifo_en != fifo_en_q;
    assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
    assign full      = count >= cap;
    assign push_ok   = push && !full && !flush;
    assign pop_ok    = pop && (count != '0) && !flush;
    assign rd_ptr_p1 = bump(rd_ptr);
    assign pop_err   = pop_ok && has_err(mem[rd_ptr]);

    assign overrun_evt = push && full && !flush;
    assign push_err    = push_ok && has_err(push_entry);
    assign not_empty   = count != '0;
    assign head_entry  = not_empty ? mem[rd_ptr] : '0;

    // Which character becomes the head at this edge
    always_comb begin
        head_load  = 1'b0;
        head_flags = '0;
        if (push_ok && (count == '0 || (pop_ok && count == CW'(1)))) begin
            head_load  = 1'b1;
            head_flags = push_entry.flags;
        end else if (pop_ok && count >= CW'(2)) begin
            head_load  = 1'b1;
            head_flags = mem[rd_ptr_p1].flags;
        end
    end

    always_comb begin
        count_n = count;
        case ({push_ok, pop_ok})
            2'b10:   count_n = count + CW'(1);
            2'b01:   count_n = count - CW'(1);
            default: count_n = count;
        endcase
        err_cnt_n = err_cnt;
        case ({push_err, pop_err})
            2'b10:   err_cnt_n = err_cnt + CW'(1);
            2'b01:   err_cnt_n = err_cnt - CW'(1);
            default: err_cnt_n = err_cnt;
        endcase
        if (flush) begin
            count_n   = '0;
            err_cnt_n = '0;
        end
    end

    assign err_none_next = err_cnt_n == '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr    <= '0;
            wr_ptr    <= '0;
            count     <= '0;
            err_cnt   <= '0;
            fifo_en_q <= fifo_en;
        end else begin
            fifo_en_q <= fifo_en;
            count     <= count_n;
            err_cnt   <= err_cnt_n;
            if (flush) begin
                rd_ptr <= '0;
                wr_ptr <= '0;
            end else begin
                if (push_ok) wr_ptr <= bump(wr_ptr);
                if (pop_ok)  rd_ptr <= rd_ptr_p1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_entry;
    end

    // R3: a dropped arrival leaves the occupancy untouched
    a_r3_drop_keeps_count: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(count));

    // R1: occupancy never exceeds the storage
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R8: errored entries are a subset of queued entries
    a_r8_errcnt_bound: assert property (@(posedge clk) disable iff (rst)
        err_cnt <= count);

    // R10: a mode change empties the queue
    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0));

endmodule

// File: rtl/uls_tx_track.sv
module uls_tx_track (
    input  logic clk,
    input  logic rst,
    input  logic thr_wr,
    input  logic tsr_load,
    input  logic tsr_done,
    output logic thr_empty,
    output logic tx_idle
);

    logic thr_full_q, tsr_full_q, take;

    assign take      = tsr_load && thr_full_q;
    assign thr_empty = !thr_full_q;
    assign tx_idle   = !thr_full_q && !tsr_full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_full_q <= 1'b0;
            tsr_full_q <= 1'b0;
        end else begin
            if (thr_wr)    thr_full_q <= 1'b1;
            else if (take) thr_full_q <= 1'b0;
            if (take)          tsr_full_q <= 1'b1;
            else if (tsr_done) tsr_full_q <= 1'b0;
        end
    end

    // R6: a holding write always leaves the holding register occupied
    a_r6_write_fills: assert property (@(posedge clk) disable iff (rst)
        thr_wr |=> !thr_empty);

    // R6: a take without a new write frees the holding register and busies the shifter
    a_r6_take_frees: assert property (@(posedge clk) disable iff (rst)
        (tsr_load && !thr_empty && !thr_wr) |=> (thr_empty && !tx_idle));

    // R7: transmitter idle implies an empty holding register
    a_r7_idle_needs_both: assert property (@(posedge clk) disable iff (rst)
        tx_idle |-> thr_empty);

endmodule

// File: rtl/uls_status.sv
module uls_status
    import uls_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       lsr_rd,
    input  logic       fifo_en,
    input  logic       overrun_evt,
    input  logic       head_load,
    input  err_flags_t head_flags,
    input  logic       push_err,
    input  logic       err_none_next,
    input  logic       data_ready,
    input  logic       thr_empty,
    input  logic       tx_idle,
    output lsr_t       lsr
);

    logic       ovr_q, sum_q;
    err_flags_t flags_q, flags_n;

    // Set wins over the read clear
    always_comb begin
        flags_n = lsr_rd ? '0 : flags_q;
        if (head_load) flags_n = flags_n | head_flags;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovr_q   <= 1'b0;
            sum_q   <= 1'b0;
            flags_q <= '0;
        end else begin
            flags_q <= flags_n;
            if (overrun_evt) ovr_q <= 1'b1;
            else if (lsr_rd) ovr_q <= 1'b0;
            if (push_err)                        sum_q <= 1'b1;
            else if (lsr_rd && err_none_next)    sum_q <= 1'b0;
        end
    end

    always_comb begin
        lsr.data_ready = data_ready;
        lsr.overrun    = ovr_q;
        lsr.perr       = flags_q.perr;
        lsr.ferr       = flags_q.ferr;
        lsr.brk        = flags_q.brk;
        lsr.thr_empty  = thr_empty;
        lsr.tx_idle    = tx_idle;
        lsr.rx_err_sum = fifo_en && sum_q;
    end

    // R3 / R11: an overrun is visible after its edge, read or not
    a_r3_overrun_sets: assert property (@(posedge clk) disable iff (rst)
        overrun_evt |=> ovr_q);

    // R4: a read with no new overrun clears the overrun bit
    a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
        (lsr_rd && !overrun_evt) |=> !ovr_q);

    // R5: head flags stay put until a status read
    a_r5_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        !lsr_rd |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

    // R8: the summary holds without a read
    a_r8_sum_holds: assert property (@(posedge clk) disable iff (rst)
        (sum_q && !lsr_rd) |=> sum_q);

endmodule

// File: rtl/uart_rx_line_status.sv
module uart_rx_line_status
    import uls_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_parity_err,
    input  logic              rx_frame_err,
    input  logic              rx_break,
    input  logic              buf_rd,
    input  logic              lsr_rd,
    input  logic              thr_wr,
    input  logic              tsr_load,
    input  logic              tsr_done,
    output logic [DATA_W-1:0] buf_data,
    output logic [LSR_W-1:0]  lsr
);

    rx_entry_t  in_entry, head_entry;
    err_flags_t head_flags;
    lsr_t       lsr_s;
    logic       not_empty, overrun_evt, push_err, head_load, err_none_next;
    logic       thr_empty, tx_idle;

    always_comb begin
        in_entry.data       = rx_data;
        in_entry.flags.perr = rx_parity_err;
        in_entry.flags.ferr = rx_frame_err;
        in_entry.flags.brk  = rx_break;
    end

    uls_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk          (clk),
        .rst          (rst),
        .fifo_en      (fifo_en),
        .push         (rx_valid),
        .push_entry   (in_entry),
        .pop          (buf_rd),
        .head_entry   (head_entry),
        .not_empty    (not_empty),
        .overrun_evt  (overrun_evt),
        .push_err     (push_err),
        .head_load    (head_load),
        .head_flags   (head_flags),
        .err_none_next(err_none_next)
    );

    uls_tx_track u_tx (
        .clk      (clk),
        .rst      (rst),
        .thr_wr   (thr_wr),
        .tsr_load (tsr_load),
        .tsr_done (tsr_done),
        .thr_empty(thr_empty),
        .tx_idle  (tx_idle)
    );

    uls_status u_status (
        .clk          (clk),
        .rst          (rst),
        .lsr_rd       (lsr_rd),
        .fifo_en      (fifo_en),
        .overrun_evt  (overrun_evt),
        .head_load    (head_load),
        .head_flags   (head_flags),
        .push_err     (push_err),
        .err_none_next(err_none_next),
        .data_ready   (not_empty),
        .thr_empty    (thr_empty),
        .tx_idle      (tx_idle),
        .lsr          (lsr_s)
    );

    assign buf_data = head_entry.data;
    assign lsr      = lsr_s;

    // R9: with the queue disabled the summary bit never shows
    a_r9_sum_masked: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> !lsr_s.rx_err_sum);

endmodule

// File: tb/uart_rx_line_status_bench.sv
module uart_rx_line_status_bench;

    localparam int CLK_PERIOD = 10;
    localparam int QDEPTH     = 16;

    logic       clk = 1'b0;
    logic       rst, fifo_en, rx_valid, rx_parity_err, rx_frame_err, rx_break;
    logic       buf_rd, lsr_rd, thr_wr, tsr_load, tsr_done;
    logic [7:0] rx_data, buf_data, lsr;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_rx_line_status u_uart_rx_line_status (
        .clk(clk), .rst(rst), .fifo_en(fifo_en), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_parity_err(rx_parity_err),
        .rx_frame_err(rx_frame_err), .rx_break(rx_break),
        .buf_rd(buf_rd), .lsr_rd(lsr_rd), .thr_wr(thr_wr),
        .tsr_load(tsr_load), .tsr_done(tsr_done),
        .buf_data(buf_data), .lsr(lsr)
    );

    // Entry layout {brk, ferr, perr, data[7:0]}
    logic [10:0] exp_q[$];
    logic m_ovr, m_pe, m_fe, m_bi, m_sum, m_thr, m_tsr, m_en;
    int n_chk = 0;
    int n_fail = 0;

    function automatic logic [7:0] exp_lsr();
        return {m_en & m_sum, !m_thr & !m_tsr, !m_thr, m_bi, m_fe, m_pe,
                m_ovr, exp_q.size() > 0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, model update and checks
    task automatic cyc(input logic rv, input logic [10:0] ent, input logic rb,
                       input logic rl, input logic tw, input logic tl,
                       input logic td, input string tag);
        int sz, cap, errs;
        logic full, pop_ok, push_ok, ovr_evt, hl, take;
        logic [2:0] hf;
        @(negedge clk);
        rx_valid = rv; rx_data = ent[7:0];
        rx_parity_err = ent[8]; rx_frame_err = ent[9]; rx_break = ent[10];
        buf_rd = rb; lsr_rd = rl; thr_wr = tw; tsr_load = tl; tsr_done = td;
        #1;
        sz = exp_q.size();
        if (rl) chk({tag, " status read value"}, lsr, exp_lsr());
        if (rb && sz > 0) chk({tag, " scoreboard data"}, buf_data, exp_q[0][7:0]);
        cap = m_en ? QDEPTH : 1;
        full = sz >= cap;
        pop_ok = rb && sz > 0;
        push_ok = rv && !full;
        ovr_evt = rv && full;
        hl = 1'b0; hf = 3'b000;
        if (push_ok && (sz == 0 || (pop_ok && sz == 1))) begin
            hl = 1'b1; hf = ent[10:8];
        end else if (pop_ok && sz >= 2) begin
            hl = 1'b1; hf = exp_q[1][10:8];
        end
        if (pop_ok) void'(exp_q.pop_front());
        if (push_ok) exp_q.push_back(ent);
        errs = 0;
        foreach (exp_q[i]) if (|exp_q[i][10:8]) errs++;
        m_ovr = ovr_evt ? 1'b1 : (rl ? 1'b0 : m_ovr);
        if (rl) begin m_pe = 0; m_fe = 0; m_bi = 0; end
        if (hl) begin m_pe |= hf[0]; m_fe |= hf[1]; m_bi |= hf[2]; end
        m_sum = (push_ok && |ent[10:8]) ? 1'b1 : ((rl && errs == 0) ? 1'b0 : m_sum);
        take = tl && m_thr;
        m_thr = tw ? 1'b1 : (take ? 1'b0 : m_thr);
        m_tsr = take ? 1'b1 : (td ? 1'b0 : m_tsr);
        @(posedge clk);
        #1;
        chk({tag, " status after edge"}, lsr, exp_lsr());
    endtask

    task automatic push(input logic [10:0] e, input string tag);
        cyc(1'b1, e, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask
    task automatic popb(input string tag);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
    endtask
    task automatic rdl(input string tag);
        cyc(1'b0, '0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, tag);
    endtask
    task automatic txc(input logic tw, input logic tl, input logic td, input string tag);
        cyc(1'b0, '0, 1'b0, 1'b0, tw, tl, td, tag);
    endtask

    task automatic set_mode(input logic en, input string tag);
        @(negedge clk);
        rx_valid = 0; buf_rd = 0; lsr_rd = 0; thr_wr = 0; tsr_load = 0; tsr_done = 0;
        fifo_en = en;
        m_en = en;
        exp_q.delete();
        @(posedge clk);
        #1;
        chk({tag, " mode change"}, lsr, exp_lsr());
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1; fifo_en = 1; rx_valid = 0; rx_data = 0; rx_parity_err = 0;
        rx_frame_err = 0; rx_break = 0; buf_rd = 0; lsr_rd = 0; thr_wr = 0;
        tsr_load = 0; tsr_done = 0;
        m_ovr = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_sum = 0; m_thr = 0; m_tsr = 0; m_en = 1;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        @(posedge clk);
        #1;
        chk("R12 reset value", lsr, 8'h60);

        // R1: empty read ignored
        popb("R1 empty buffer read");
        // R1/R2: ordering of clean characters
        push({3'b000, 8'hA1}, "R1 push A1");
        push({3'b000, 8'h5C}, "R2 push 5C");
        push({3'b000, 8'h3E}, "R2 push 3E");
        rdl("R4 clean read");
        popb("R2 pop 1"); popb("R2 pop 2"); popb("R2 pop 3");
        popb("R1 pop when empty");

        // R5/R8: flags follow the head
        push({3'b000, 8'h11}, "R5 clean head");
        push({3'b001, 8'h22}, "R8 parity char");
        push({3'b110, 8'h33}, "R5 framing+break char");
        rdl("R8 summary held");
        popb("R5 parity reaches head");
        rdl("R4 clears parity");
        popb("R5 framing break reach head");
        rdl("R8 summary still held");
        popb("R5 drain");
        rdl("R8 summary clears");

        // R3: overrun
        for (int i = 0; i < QDEPTH; i++) push({3'b000, 8'(i * 7 + 3)}, "R3 fill");
        push({3'b000, 8'hEE}, "R3 overrun drop");
        cyc(1'b1, {3'b000, 8'hED}, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3 full with pop");
        push({3'b000, 8'h77}, "R3 refill");
        cyc(1'b1, {3'b000, 8'hEC}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 overrun with read");
        rdl("R4 overrun cleared");
        for (int i = 0; i < QDEPTH; i++) popb("R2 drain order");

        // R11: head flag set while reading
        cyc(1'b1, {3'b011, 8'h44}, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R11 head flags with read");
        rdl("R4 flags cleared");
        popb("R8 pop errored");
        rdl("R8 summary clears after pop");

        // R6/R7: transmit occupancy
        txc(1'b0, 1'b1, 1'b0, "R6 load while empty ignored");
        txc(1'b1, 1'b0, 1'b0, "R6 holding write");
        txc(1'b0, 1'b1, 1'b0, "R7 take into shifter");
        txc(1'b0, 1'b0, 1'b1, "R7 shifter done");
        txc(1'b1, 1'b0, 1'b0, "R6 write again");
        txc(1'b1, 1'b1, 1'b0, "R6 write with take");
        txc(1'b0, 1'b1, 1'b1, "R7 take with done");
        txc(1'b0, 1'b0, 1'b1, "R7 idle again");

        // R9/R10: disabled queue
        push({3'b000, 8'h90}, "R10 before flush");
        push({3'b100, 8'h91}, "R10 before flush err");
        set_mode(1'b0, "R10 flush on disable");
        rdl("R8 summary read after flush");
        push({3'b001, 8'h92}, "R9 errored char hidden");
        push({3'b000, 8'h93}, "R9 single slot overrun");
        rdl("R4 read in disabled mode");
        popb("R9 pop single");
        set_mode(1'b1, "R10 enable again");
        rdl("R8 final read");

        summary();
        $finish;
    end

endmodule